// File: doc/BRIEF.md
# Inbound Memory Window Filter

This block sits between the link side of a PCIe root port and the system memory fabric. Each inbound memory request presents an address and a tag. The block compares the address against a set of programmable windows, each bounded by a start and a limit address, and returns a pass or block verdict one clock later. The tag comes back with the verdict so that the requester can match it to the request. A single polarity bit sets the meaning of the windows. In one setting they describe what may reach memory. In the other they describe what must be kept away from it.

Software programs the block through a small register port. There is one control register and a start and limit pair for each window. A window is switched off by writing a start value that is above its limit, so that no address can fall inside it. After reset every window is off and the polarity bit selects exclusive mode, so all traffic passes until software sets up the windows. Register writes are single-cycle strobes and readback is combinational from the offset.

Top module: `inbound_win_filter`

## Requirements
- R1: After reset the control register reads 0, every window start reads 0xFFFFFFFF, every window limit reads 0, and rsp_valid is low.
- R2: The control register sits at offset 0x00 and only bit 0 (1 = inclusive) is stored, so other bits read as 0. Window n has its start at offset 0x10+8n and its limit at offset 0x14+8n, and both hold the full 32-bit value as written.
- R3: An address is inside window n when start <= addr <= limit, compared as unsigned 32-bit numbers with both bounds included and no alignment applied.
- R4: In inclusive mode (control bit 0 = 1) a request passes when its address is inside at least one window, and is blocked otherwise.
- R5: In exclusive mode (control bit 0 = 0) a request passes only when its address is inside no window.
- R6: A window whose start is greater than its limit contains no address.
- R7: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and rsp_tag then equals that request's req_tag.
- R8: Writes to an offset that maps to no register change no register and no verdict, and reads of such an offset return 0.
- R9: A verdict uses the register values from before any write made in the same cycle as the request. The write affects later requests only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the register at reg_addr |
| req_valid | input | 1 | Inbound request present |
| req_addr | input | 32 | Inbound request byte address |
| req_tag | input | 8 | Request identifier |
| rsp_valid | output | 1 | Verdict present |
| rsp_pass | output | 1 | 1 = forward to memory, 0 = block |
| rsp_tag | output | 8 | Tag of the request this verdict belongs to |

## Verification
A stored bound that has gone wrong shows up at the ports in two ways. A register read returns the bad value in the same cycle. The next request whose address lies near that bound gets the wrong verdict one cycle later. The bench therefore probes addresses just inside and just outside each bound, and the extremes 0 and 0xFFFFFFFF. A polarity bit that has gone wrong flips every verdict at once. A tag or valid pipeline that has slipped shows as a mismatch on the very next response. Same-cycle writes and requests are used to reveal a verdict that reads a bound too late.

// File: rtl/inbound_win_filter_pkg.sv
package inbound_win_filter_pkg;

  localparam int unsigned REG_OFS_W   = 8;
  localparam int unsigned IDX_W       = 4;
  localparam logic [REG_OFS_W-1:0] CTRL_OFS    = 8'h00;
  localparam logic [REG_OFS_W-1:0] WIN_BASE_OFS = 8'h10;

  typedef struct packed {
    logic             is_ctrl;
    logic             is_win;
    logic             is_limit;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  // Map a byte offset onto a register; windows are 8 bytes apart
  function automatic reg_sel_t decode_ofs(input logic [REG_OFS_W-1:0] ofs,
                                          input int unsigned nwin);
    reg_sel_t             s;
    logic [REG_OFS_W-1:0] rel;
    s   = '0;
    rel = ofs - WIN_BASE_OFS;
    if (ofs == CTRL_OFS) begin
      s.is_ctrl = 1'b1;
    end else if (ofs >= WIN_BASE_OFS && ofs[1:0] == 2'b00 &&
                 32'(rel[REG_OFS_W-1:3]) < nwin) begin
      s.is_win   = 1'b1;
      s.is_limit = rel[2];
      s.idx      = rel[IDX_W+2:3];
    end
    return s;
  endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
  import inbound_win_filter_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned NUM_WIN = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_OFS_W-1:0]          ofs,
  input  logic [AW-1:0]                 wdata,
  output logic [AW-1:0]                 rdata,
  output logic                          incl_o,
  output logic [NUM_WIN-1:0][AW-1:0]    start_o,
  output logic [NUM_WIN-1:0][AW-1:0]    limit_o
);

  reg_sel_t sel;
  assign sel = decode_ofs(ofs, NUM_WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      incl_o <= 1'b0;
    end else if (wr_en && sel.is_ctrl) begin
      incl_o <= wdata[0];
    end
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic hit_wr;
    assign hit_wr = wr_en && sel.is_win && (sel.idx == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_o[gi] <= '1;
        limit_o[gi] <= '0;
      end else if (hit_wr) begin
        if (sel.is_limit) limit_o[gi] <= wdata;
        else              start_o[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel.is_ctrl) rdata[0] = incl_o;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel.is_win && sel.idx == IDX_W'(i))
        rdata = sel.is_limit ? limit_o[i] : start_o[i];
    end
  end

endmodule

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] limit_i,
  output logic          hit_o
);

  // Both bounds inclusive; start above limit yields no match
  function automatic logic addr_in_range(input logic [AW-1:0] a,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign hit_o = addr_in_range(addr_i, start_i, limit_i);

endmodule

// File: rtl/win_decide.sv
module win_decide #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic               incl_i,
  output logic               rsp_valid,
  output logic               rsp_pass,
  output logic [TAG_W-1:0]   rsp_tag
);

  function automatic logic verdict(input logic any_hit, input logic incl);
    return incl ? any_hit : !any_hit;
  endfunction

  logic any_hit;
  assign any_hit = |hit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pass  <= 1'b0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pass <= verdict(any_hit, incl_i);
        rsp_tag  <= req_tag;
      end
    end
  end

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R7
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R7
  tag_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_tag == $past(req_tag));
  // R4
  incl_hit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && incl_i && any_hit) |=> rsp_pass);
  // R5
  excl_hit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !incl_i && any_hit) |=> !rsp_pass);

endmodule

// File: rtl/inbound_win_filter.sv
module inbound_win_filter
  import inbound_win_filter_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned NUM_WIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_OFS_W-1:0] reg_addr,
  input  logic [AW-1:0]        reg_wdata,
  output logic [AW-1:0]        reg_rdata,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [TAG_W-1:0]     req_tag,
  output logic                 rsp_valid,
  output logic                 rsp_pass,
  output logic [TAG_W-1:0]     rsp_tag
);

  logic                       incl;
  logic [NUM_WIN-1:0][AW-1:0] win_start;
  logic [NUM_WIN-1:0][AW-1:0] win_limit;
  logic [NUM_WIN-1:0]         win_hit;

  win_regs #(.AW(AW), .NUM_WIN(NUM_WIN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .ofs     (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .incl_o  (incl),
    .start_o (win_start),
    .limit_o (win_limit)
  );

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_match
    win_match #(.AW(AW)) u_match (
      .addr_i  (req_addr),
      .start_i (win_start[gi]),
      .limit_i (win_limit[gi]),
      .hit_o   (win_hit[gi])
    );

    // R6
    empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start[gi] > win_limit[gi]) |-> !win_hit[gi]);
  end

  win_decide #(.NUM_WIN(NUM_WIN), .TAG_W(TAG_W)) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_tag   (req_tag),
    .hit_i     (win_hit),
    .incl_i    (incl),
    .rsp_valid (rsp_valid),
    .rsp_pass  (rsp_pass),
    .rsp_tag   (rsp_tag)
  );

endmodule

// File: tb/inbound_win_filter_tb_top.sv
module inbound_win_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_tag = '0;
  logic        rsp_valid;
  logic        rsp_pass;
  logic [7:0]  rsp_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit          m_incl;
  logic [31:0] m_lo[2];
  logic [31:0] m_hi[2];

  always #4 clk = ~clk;

  inbound_win_filter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_pass(rsp_pass), .rsp_tag(rsp_tag)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_incl};
    if (a inside {8'h10, 8'h14, 8'h18, 8'h1C}) begin
      int w = (a - 8'h10) / 8;
      return (a % 8 == 4) ? m_hi[w] : m_lo[w];
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_incl = d[0];
      8'h10: m_lo[0] = d;
      8'h14: m_hi[0] = d;
      8'h18: m_lo[1] = d;
      8'h1C: m_hi[1] = d;
      default: ;
    endcase
  endtask

  function automatic bit model_pass(input logic [31:0] a);
    bit inside_any = 0;
    for (int w = 0; w < 2; w++)
      if (a >= m_lo[w] && a <= m_hi[w]) inside_any = 1;
    return m_incl ? inside_any : !inside_any;
  endfunction

  // One cycle: drive at negedge, check readback, advance, check response
  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                      input string rd_rq, input bit rv, input logic [31:0] ra,
                      input logic [7:0] tg, input string rq);
    bit exp_pass;
    reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    req_valid = rv; req_addr = ra; req_tag = tg;
    #1;
    check(rd_rq, reg_rdata, model_read(a));
    exp_pass = model_pass(ra);
    if (wr) model_write(a, wd);
    @(posedge clk);
    @(negedge clk);
    check("R7", {31'b0, rsp_valid}, {31'b0, rv});
    if (rv) begin
      check("R7", {24'b0, rsp_tag}, {24'b0, tg});
      check(rq, {31'b0, rsp_pass}, {31'b0, exp_pass});
    end
    reg_wr_en = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, "R2", 0, 0, 0, "R2");
  endtask

  task automatic rq(input logic [31:0] a, input logic [7:0] t, input string r);
    step(0, 8'h00, 0, "R2", 1, a, t, r);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_incl = 0;
    for (int w = 0; w < 2; w++) begin m_lo[w] = '1; m_hi[w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    // R1 reset contents
    step(0, 8'h00, 0, "R1", 0, 0, 0, "R1");
    step(0, 8'h10, 0, "R1", 0, 0, 0, "R1");
    step(0, 8'h14, 0, "R1", 0, 0, 0, "R1");
    step(0, 8'h18, 0, "R1", 0, 0, 0, "R1");
    step(0, 8'h1C, 0, "R1", 0, 0, 0, "R1");
    // R6 / R5: both windows empty, exclusive -> everything passes
    rq(32'h0000_0000, 8'h01, "R6");
    rq(32'hFFFF_FFFF, 8'h02, "R6");
    // R3 / R4: inclusive with window 0 = 0x1000..0x1FFF
    wr(8'h10, 32'h0000_1000);
    wr(8'h14, 32'h0000_1FFF);
    wr(8'h00, 32'h0000_0001);
    step(0, 8'h10, 0, "R2", 0, 0, 0, "R2");
    step(0, 8'h14, 0, "R2", 0, 0, 0, "R2");
    rq(32'h0000_0FFF, 8'h10, "R3");
    rq(32'h0000_1000, 8'h11, "R3");
    rq(32'h0000_1FFF, 8'h12, "R3");
    rq(32'h0000_2000, 8'h13, "R3");
    // window 1 covers upper half
    wr(8'h18, 32'h8000_0000);
    wr(8'h1C, 32'hFFFF_FFFF);
    rq(32'hFFFF_FFFF, 8'h20, "R4");
    rq(32'h7FFF_FFFF, 8'h21, "R4");
    rq(32'h8000_0000, 8'h22, "R4");
    // R5 exclusive
    wr(8'h00, 32'h0000_0000);
    rq(32'h0000_1500, 8'h30, "R5");
    rq(32'h0000_3000, 8'h31, "R5");
    rq(32'h8000_0001, 8'h32, "R5");
    // R2: only bit 0 of control is kept
    wr(8'h00, 32'hFFFF_FFFE);
    step(0, 8'h00, 0, "R2", 0, 0, 0, "R2");
    wr(8'h00, 32'hFFFF_FFFF);
    step(0, 8'h00, 0, "R2", 0, 0, 0, "R2");
    // R8: unmapped offsets ignored
    wr(8'h04, 32'hDEAD_BEEF);
    step(0, 8'h04, 0, "R8", 0, 0, 0, "R8");
    wr(8'h20, 32'h0000_0000);
    step(0, 8'h20, 0, "R8", 0, 0, 0, "R8");
    wr(8'h12, 32'h0000_0000);
    step(0, 8'h10, 0, "R8", 0, 0, 0, "R8");
    rq(32'h0000_1000, 8'h40, "R8");
    // R6: start above limit disables window 0
    wr(8'h10, 32'h0000_3000);
    wr(8'h14, 32'h0000_2000);
    rq(32'h0000_2800, 8'h50, "R6");
    rq(32'h0000_3000, 8'h51, "R6");
    // R9: write in same cycle as request
    step(1, 8'h00, 32'h0, "R2", 1, 32'h0000_0100, 8'h60, "R9");
    rq(32'h0000_0100, 8'h61, "R9");
    step(1, 8'h1C, 32'h8000_0000, "R2", 1, 32'h9000_0000, 8'h62, "R9");
    rq(32'h9000_0000, 8'h63, "R9");
    // back-to-back requests with varied tags
    for (int k = 0; k < 8; k++)
      rq(32'h7FFF_FFFC + 32'(k), 8'(8'hA0 + k), "R4");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule